// File: doc/BRIEF.md
# Latched Fault Alert Controller

This block drives an active-low alert line that tells a bus host that the power stage's monitored state has moved. It watches a vector of condition flags: voltage excursions on input and output, output overcurrent, temperature, fan failure, communication, checksum and invalid-command errors, and internal faults. It pulls the alert low whenever any flag differs from its value in the previous cycle. The low level is latched and stays put after the flag that caused it has returned to normal.

Four events release the alert. Two are single-cycle pulses from the command decoder: a clear-all-faults command and a read of the combined status word. The other two are off-then-on recycles of the main output, one seen on the enable pin level and one on the commanded output-on state. A recycle counts only if an off level was observed before the on level. If any condition flag is still set in the cycle after a release, the alert goes low again and latches. When a release and a new change fall in the same cycle, the change wins. The output pad is expected to drive low when `alert_n_o` is 0 and to float otherwise.

Top module: `alert_latch_ctl`

## Requirements
- R1: During and after reset, with all condition flags at 0, `alert_n_o` is 1.
- R2: When any bit of `status_i` goes from 0 to 1, `alert_n_o` is 0 after the next rising clock edge. This holds for the lowest bit and for the highest bit.
- R3: When a bit of `status_i` goes from 1 to 0, this also drives `alert_n_o` to 0 after the next edge.
- R4: Once `alert_n_o` is 0, it stays 0 while `status_i` is steady and no release event occurs, even with all flags at 0.
- R5: A one-cycle pulse on `clr_faults_i` releases the alert, so `alert_n_o` is 1 after that edge. A pulse while the alert is already released leaves it at 1.
- R6: A one-cycle pulse on `stat_word_rd_i` releases the alert in the same way.
- R7: `enable_pin_i` observed at 0 and later at 1 releases the alert on the edge that samples the 1.
- R8: `out_on_i` observed at 0 and later at 1 releases the alert in the same way.
- R9: A falling level on `enable_pin_i` or `out_on_i` on its own does not release the alert.
- R10: If any `status_i` bit is 1 in the cycle after a release, `alert_n_o` goes back to 0 on the following edge. It is therefore high for exactly one cycle.
- R11: When a release event and a change of `status_i` fall in the same cycle, `alert_n_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | NCOND | Condition flags, 1 = condition present |
| clr_faults_i | input | 1 | One-cycle pulse: clear-all-faults command received |
| stat_word_rd_i | input | 1 | One-cycle pulse: status word was read |
| enable_pin_i | input | 1 | Enable pin level, 1 = output on |
| out_on_i | input | 1 | Commanded output state, 1 = output on |
| alert_n_o | output | 1 | Alert, 0 = asserted (pad pulls low) |

## Verification
The bench builds the block with NCOND set to 4. This puts the lowest and highest condition bits, and a middle bit, a few steps apart, so both ends of the change comparator are exercised directly. The narrow vector also makes it easy to reach the one-cycle release window: a flag is dropped exactly in that window, so the falling-edge path can be told apart from the re-latch path. Both recycle sources run through off-only and off-then-on sequences. A release is also made to collide with a fresh change.

// File: rtl/alert_pkg.sv
package alert_pkg;

   // Sources whose off-then-on sequence counts as a release.
   typedef enum int unsigned {
      REC_PIN    = 0,
      REC_OPCMD  = 1,
      REC_COUNT  = 2
   } rec_src_e;

   localparam int unsigned MAX_COND = 64;

endpackage

// File: rtl/status_change_det.sv
module status_change_det #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags_i,
   output logic         change_o,
   output logic         any_set_o
);

   logic [W-1:0] hist_q;
   logic [W-1:0] diff;

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q[b] <= 1'b0;
            else        hist_q[b] <= flags_i[b];
         end
         assign diff[b] = flags_i[b] ^ hist_q[b];
      end
   endgenerate

   assign change_o  = |diff;
   assign any_set_o = |flags_i;

endmodule

// File: rtl/recycle_track.sv
module recycle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic release_o
);

   logic prev_q;
   logic armed_q;
   logic fell;
   logic rose;

   assign fell      = prev_q & ~level_i;
   assign rose      = ~prev_q & level_i;
   assign release_o = rose & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q <= level_i;
         if (fell)      armed_q <= 1'b1;
         else if (rose) armed_q <= 1'b0;
      end
   end

   // R9: an off level never produces a release
   a_r9_off_no_release: assert property (@(posedge clk) disable iff (!rst_n)
      !level_i |-> !release_o);

   // R7/R8: a release is a single pulse per on transition
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |=> !release_o);

endmodule

// File: rtl/alert_latch_core.sv
module alert_latch_core (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic release_i,
   input  logic any_set_i,
   output logic alert_n_o
);

   logic latch_q;
   logic rel_q;
   logic set_all;

   // Re-latch when a condition is still present one cycle after a release.
   assign set_all = set_i | (rel_q & any_set_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
         rel_q   <= 1'b0;
      end else begin
         rel_q <= release_i & ~set_all;
         if (set_all)        latch_q <= 1'b1;
         else if (release_i) latch_q <= 1'b0;
      end
   end

   assign alert_n_o = ~latch_q;

   a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!alert_n_o && !release_i) |=> !alert_n_o);

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> !alert_n_o);

   a_r10_relatch: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_q && any_set_i) |=> !alert_n_o);

   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !set_i && !(rel_q && any_set_i)) |=> alert_n_o);

endmodule

// File: rtl/alert_latch_ctl.sv
module alert_latch_ctl
   import alert_pkg::*;
#(
   parameter int unsigned NCOND = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCOND-1:0] status_i,
   input  logic             clr_faults_i,
   input  logic             stat_word_rd_i,
   input  logic             enable_pin_i,
   input  logic             out_on_i,
   output logic             alert_n_o
);

   localparam int unsigned NREC = int'(REC_COUNT);

   generate
      if (NCOND < 1 || NCOND > MAX_COND) begin : g_bad_width
         $error("alert_latch_ctl: NCOND out of range");
      end
   endgenerate

   logic            change;
   logic            any_set;
   logic [NREC-1:0] rec_lvl;
   logic [NREC-1:0] rec_rel;
   logic            release_any;

   assign rec_lvl[REC_PIN]   = enable_pin_i;
   assign rec_lvl[REC_OPCMD] = out_on_i;

   status_change_det #(.W(NCOND)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (status_i),
      .change_o  (change),
      .any_set_o (any_set)
   );

   generate
      for (genvar s = 0; s < NREC; s++) begin : g_rec
         recycle_track u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (rec_lvl[s]),
            .release_o (rec_rel[s])
         );
      end
   endgenerate

   assign release_any = clr_faults_i | stat_word_rd_i | (|rec_rel);

   alert_latch_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (change),
      .release_i (release_any),
      .any_set_i (any_set),
      .alert_n_o (alert_n_o)
   );

   // R1: alert released while the block is held in reset
   a_r1_reset_high: assert property (@(posedge clk) !rst_n |-> alert_n_o);

endmodule

// File: tb/alert_latch_ctl_test.sv
module alert_latch_ctl_test;

   localparam int unsigned NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] status = '0;
   logic          clr = 1'b0;
   logic          rd = 1'b0;
   logic          en = 1'b1;
   logic          on = 1'b1;
   logic          alert_n;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   bit    q_exp[$];
   string q_tag[$];

   always #5 clk = ~clk;

   alert_latch_ctl #(.NCOND(NC)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .status_i       (status),
      .clr_faults_i   (clr),
      .stat_word_rd_i (rd),
      .enable_pin_i   (en),
      .out_on_i       (on),
      .alert_n_o      (alert_n)
   );

   // Driver: apply one cycle of inputs and queue the alert level expected after the edge.
   task automatic cyc(input logic [NC-1:0] s, input logic c, input logic r,
                      input logic e, input logic o, input bit exp, input string tag);
      @(negedge clk);
      status = s; clr = c; rd = r; en = e; on = o;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   // Monitor: sample between the edge and the next drive.
   always begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
         bit    e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         compared++;
         if (alert_n !== e) begin
            mismatched++;
            $display("FAIL %s: alert_n_o actual %b expected %b", t, alert_n, e);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      #3;
      compared++;
      if (alert_n !== 1'b1) begin
         mismatched++;
         $display("FAIL R1: alert_n_o in reset actual %b expected 1", alert_n);
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      cyc(4'b0000, 0, 0, 1, 1, 1, "R1");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R1");

      // R2 lowest bit, R4 hold, R3 falling while already latched
      cyc(4'b0001, 0, 0, 1, 1, 0, "R2");
      cyc(4'b0001, 0, 0, 1, 1, 0, "R4");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R4");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R4");
      // R5 clear-faults release, and a redundant clear
      cyc(4'b0000, 1, 0, 1, 1, 1, "R5");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R5");
      cyc(4'b0000, 1, 0, 1, 1, 1, "R5");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R5");

      // R2 highest bit, R6 status-word read release
      cyc(4'b1000, 0, 0, 1, 1, 0, "R2");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R4");
      cyc(4'b0000, 0, 1, 1, 1, 1, "R6");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R6");

      // R10 re-latch while a condition persists
      cyc(4'b0100, 0, 0, 1, 1, 0, "R2");
      cyc(4'b0100, 1, 0, 1, 1, 1, "R10");
      cyc(4'b0100, 0, 0, 1, 1, 0, "R10");
      cyc(4'b0100, 0, 0, 1, 1, 0, "R10");
      // R3: release, then drop the flag inside the one-cycle high window
      cyc(4'b0100, 1, 0, 1, 1, 1, "R10");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R3");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R3");
      cyc(4'b0000, 1, 0, 1, 1, 1, "R5");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R5");

      // R11: release and change collide
      cyc(4'b0010, 1, 0, 1, 1, 0, "R11");
      cyc(4'b0000, 0, 1, 1, 1, 0, "R11");
      cyc(4'b0000, 0, 1, 1, 1, 1, "R6");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R6");

      // R7/R9 enable pin recycle
      cyc(4'b0001, 0, 0, 1, 1, 0, "R2");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R4");
      cyc(4'b0000, 0, 0, 0, 1, 0, "R9");
      cyc(4'b0000, 0, 0, 0, 1, 0, "R9");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R7");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R7");

      // R8/R9 commanded output recycle
      cyc(4'b0010, 0, 0, 1, 1, 0, "R2");
      cyc(4'b0000, 0, 0, 1, 1, 0, "R4");
      cyc(4'b0000, 0, 0, 1, 0, 0, "R9");
      cyc(4'b0000, 0, 0, 1, 0, 0, "R9");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R8");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R8");

      // R9: off seen before the latch sets still arms the on edge
      cyc(4'b0000, 0, 0, 1, 0, 1, "R9");
      cyc(4'b1000, 0, 0, 1, 0, 0, "R2");
      cyc(4'b0000, 0, 0, 1, 0, 0, "R9");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R8");
      cyc(4'b0000, 0, 0, 1, 1, 1, "R8");

      repeat (3) @(posedge clk);
      #3;
      finish_run();
   end

endmodule